// File: doc/BRIEF.md
# Hourly Chime and Streamed Note Player

This block drives a square-wave buzzer pin. It has two sources of sound. During the first thirty seconds of every hour it plays a built-in 64-step melody. At any other time it plays single notes that arrive as byte codes from a serial receiver. While streamed notes are arriving, it raises a flag that tells the display logic to stop refreshing the time and temperature. The flag drops again once a whole 1 Hz tick interval passes with no new byte.

The block also emits a one-cycle request at the top of every hour. The surrounding system uses this request to send out the current temperature reading, the same value that is shown locally. The timekeeping counter and the serial receiver sit outside the block. They supply the BCD minute digits, the seconds-tens digit, the 1 Hz tick and a byte-valid strobe with its data.

Pitch is set by a half-period count. The count is derived when the design is elaborated, from the clock frequency and a table of tempered note frequencies. The same RTL therefore serves a 12 MHz build and a scaled-down configuration.

Top module: `chime_player`

## Requirements
- R1: While reset is asserted, and in the cycles after it is released before any stimulus, `buzzer`, `hold_display` and `report_req` are 0.
- R2: Note code n in 1..21 sounds with half-period D = floor(CLK_HZ*100 / (2*f)) clock cycles.
  - f is given in centihertz.
  - Degree (n-1) mod 7 picks one of the base values 26163, 29366, 32963, 34923, 39200, 44000, 49388.
  - That base value is doubled once for each octave (n-1)/7.
  - Codes 1-7 form the low octave, 8-14 the middle octave and 15-21 the high octave.
- R3: A received byte whose value is outside 1..21 (for example 0x00, 0x16, 0x80 or 0xFF) selects silence. `buzzer` stays 0, and the byte still raises `hold_display`.
- R4: Every cycle in which `rx_valid` is high makes `hold_display` 1 in the following cycle.
- R5: On a `tick_1hz` cycle, `hold_display` is released if no byte has arrived since the previous tick. A byte in the same cycle as a tick counts as new. After a byte, the first tick therefore keeps the hold and the second tick releases it.
- R6: The hourly window is open when `chime_en` is 1, both minute digits are 0 and `sec_tens` is below WINDOW_TENS (default 3).
  - While the window is open, the melody steps every NOTE_CYCLES cycles and wraps from step 63 to step 0.
  - Step s plays code M[s], where M is 10,10,11,12,12,11,10,9,8,8,9,10,3,2,2,10, 10,11,12,12,11,10,9,8,8,9,10,2,1,1,9,9, 10,8,9,10,11,10,8,9,10,11,10,9,8,9,5,10, 10,10,11,12,12,11,10,11,9,8,8,9,10,2,8,8.
- R7: With the window closed and `hold_display` 0, `buzzer` is 0 from the next cycle on. Each time the window opens, the melody starts again at step 0.
- R8: While the window is open, the melody takes priority over a streamed note.
- R9: `report_req` is high for exactly one cycle, the cycle after a `tick_1hz` at which the minutes are 00 and `sec_tens` is 0, if at the previous tick that condition did not hold. It does not depend on `chime_en`.
- R10: With `chime_en` at 0, the melody does not sound even when the time digits match the window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| chime_en | input | 1 | Enables the hourly melody |
| min_tens | input | 4 | BCD tens digit of minutes |
| min_ones | input | 4 | BCD ones digit of minutes |
| sec_tens | input | 4 | BCD tens digit of seconds |
| rx_valid | input | 1 | One-cycle strobe for a received byte |
| rx_byte | input | 8 | Received note code |
| tick_1hz | input | 1 | One-cycle pulse once per second |
| buzzer | output | 1 | Square-wave buzzer drive |
| hold_display | output | 1 | Freeze request for the time and temperature display |
| report_req | output | 1 | One-cycle temperature report request at the top of the hour |

## Verification
The hardest condition to reach from the ports is the melody wrapping from step 63 back to step 0. It needs the window held open for 64 full note lengths without a break. The bench therefore shrinks the note length to 1200 cycles and the clock figure to 120 kHz. It then keeps the time digits fixed at 00:0x for 65 steps and measures the buzzer half-period in the middle of every step against the melody table. The release rule for the display hold depends on how bytes and ticks interleave. The bench builds those interleavings on purpose, including a byte that lands in the same cycle as a tick.

// File: rtl/chime_pkg.sv
package chime_pkg;

  localparam int unsigned NOTE_CODES = 21;
  localparam int unsigned DEGREES    = 7;
  localparam int unsigned MEL_STEPS  = 64;
  localparam int unsigned CODE_W     = 5;
  localparam int unsigned STEP_W     = $clog2(MEL_STEPS);

  typedef logic [CODE_W-1:0] note_code_t;
  typedef logic [STEP_W-1:0] step_t;

  // Tempered frequency of each scale degree in the lowest octave, centihertz.
  function automatic longint unsigned degree_chz(input int unsigned deg);
    case (deg)
      0:       return 64'd26163;
      1:       return 64'd29366;
      2:       return 64'd32963;
      3:       return 64'd34923;
      4:       return 64'd39200;
      5:       return 64'd44000;
      default: return 64'd49388;
    endcase
  endfunction

  // Half-period in clock cycles for a note code; 0 marks silence.
  function automatic longint unsigned half_count(input longint unsigned clk_hz,
                                                 input int unsigned code,
                                                 input longint unsigned cap);
    longint unsigned f;
    longint unsigned d;
    if (code == 0 || code > NOTE_CODES) return 64'd0;
    f = degree_chz((code - 1) % DEGREES) << ((code - 1) / DEGREES);
    d = (clk_hz * 64'd100) / (64'd2 * f);
    if (d > cap) d = cap;
    if (d == 0) d = 64'd1;
    return d;
  endfunction

  // Hourly melody, grouped by the note each step plays.
  function automatic note_code_t melody_code(input step_t s);
    case (s)
      6'd0, 6'd1, 6'd6, 6'd11, 6'd15, 6'd16, 6'd21, 6'd26, 6'd32,
      6'd35, 6'd37, 6'd40, 6'd42, 6'd47, 6'd48, 6'd49, 6'd54, 6'd60:
        return 5'd10;
      6'd2, 6'd5, 6'd17, 6'd20, 6'd36, 6'd41, 6'd50, 6'd53, 6'd55:
        return 5'd11;
      6'd3, 6'd4, 6'd18, 6'd19, 6'd51, 6'd52:
        return 5'd12;
      6'd7, 6'd10, 6'd22, 6'd25, 6'd30, 6'd31, 6'd34, 6'd39, 6'd43,
      6'd45, 6'd56, 6'd59:
        return 5'd9;
      6'd8, 6'd9, 6'd23, 6'd24, 6'd33, 6'd38, 6'd44, 6'd57, 6'd58,
      6'd62, 6'd63:
        return 5'd8;
      6'd13, 6'd14, 6'd27, 6'd61:
        return 5'd2;
      6'd28, 6'd29:
        return 5'd1;
      6'd12:
        return 5'd3;
      6'd46:
        return 5'd5;
      default:
        return 5'd0;
    endcase
  endfunction

  // Received byte to note code; anything outside the note range is silence.
  function automatic note_code_t byte_to_code(input logic [7:0] b);
    if (b >= 8'd1 && b <= 8'(NOTE_CODES)) return b[CODE_W-1:0];
    return '0;
  endfunction

endpackage

// File: rtl/chime_rst_sync.sv
module chime_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_q
);

  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= 2'b00;
    end else begin
      sync_q <= {sync_q[0], 1'b1};
    end
  end

  assign rst_q = sync_q[1];

endmodule

// File: rtl/chime_pitch_rom.sv
module chime_pitch_rom
  import chime_pkg::*;
#(
  parameter int unsigned CLK_HZ = 12_000_000,
  parameter int unsigned CNT_W  = 16
) (
  input  note_code_t       code_i,
  output logic [CNT_W-1:0] half_o
);

  localparam int unsigned     ENTRIES = NOTE_CODES + 1;
  localparam longint unsigned CAP     = (64'd1 << CNT_W) - 64'd1;

  logic [CNT_W-1:0] tab [ENTRIES];

  for (genvar g = 0; g < ENTRIES; g++) begin : g_note
    localparam longint unsigned HV = half_count(64'(CLK_HZ), g, CAP);
    assign tab[g] = CNT_W'(HV);
  end

  always_comb begin
    half_o = '0;
    if (code_i <= CODE_W'(NOTE_CODES)) begin
      half_o = tab[code_i];
    end
  end

endmodule

// File: rtl/chime_stream_ctl.sv
module chime_stream_ctl
  import chime_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rx_valid,
  input  logic [7:0] rx_byte,
  input  logic       tick_1hz,
  output logic       hold_o,
  output note_code_t code_o
);

  logic       hold_q, hold_d;
  logic       fresh_q, fresh_d;
  note_code_t code_q, code_d;

  always_comb begin
    hold_d  = hold_q;
    fresh_d = fresh_q;
    code_d  = code_q;
    if (rx_valid) begin
      hold_d  = 1'b1;
      fresh_d = 1'b1;
      code_d  = byte_to_code(rx_byte);
    end else if (tick_1hz) begin
      if (fresh_q) begin
        fresh_d = 1'b0;
      end else begin
        hold_d = 1'b0;
        code_d = '0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q  <= 1'b0;
      fresh_q <= 1'b0;
      code_q  <= '0;
    end else begin
      hold_q  <= hold_d;
      fresh_q <= fresh_d;
      code_q  <= code_d;
    end
  end

  assign hold_o = hold_q;
  assign code_o = code_q;

endmodule

// File: rtl/chime_melody_seq.sv
module chime_melody_seq
  import chime_pkg::*;
#(
  parameter int unsigned NOTE_CYCLES = 3_000_000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       window_i,
  output note_code_t code_o
);

  localparam int unsigned      BEAT_W    = (NOTE_CYCLES > 1) ? $clog2(NOTE_CYCLES) : 1;
  localparam logic [BEAT_W-1:0] BEAT_LAST = BEAT_W'(NOTE_CYCLES - 1);

  logic [BEAT_W-1:0] beat_q, beat_d;
  step_t             step_q, step_d;
  logic              beat_end;

  always_comb begin
    beat_end = (beat_q == BEAT_LAST);
    beat_d   = beat_q;
    step_d   = step_q;
    if (!window_i) begin
      beat_d = '0;
      step_d = '0;
    end else if (beat_end) begin
      beat_d = '0;
      step_d = step_q + 1'b1;
    end else begin
      beat_d = beat_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      beat_q <= '0;
      step_q <= '0;
    end else begin
      beat_q <= beat_d;
      step_q <= step_d;
    end
  end

  assign code_o = window_i ? melody_code(step_q) : '0;

endmodule

// File: rtl/chime_tone_gen.sv
module chime_tone_gen
  import chime_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  note_code_t       code_i,
  input  logic [CNT_W-1:0] half_i,
  output logic             tone_o
);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             tone_q, tone_d;
  note_code_t       last_q;
  logic             silent, retune, wrap;

  always_comb begin
    silent = (code_i == '0) || (half_i == '0);
    retune = (code_i != last_q);
    wrap   = (cnt_q == half_i - CNT_W'(1));
    cnt_d  = cnt_q + CNT_W'(1);
    tone_d = tone_q;
    if (silent || retune) begin
      cnt_d  = '0;
      tone_d = 1'b0;
    end else if (wrap) begin
      cnt_d  = '0;
      tone_d = ~tone_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      tone_q <= 1'b0;
      last_q <= '0;
    end else begin
      cnt_q  <= cnt_d;
      tone_q <= tone_d;
      last_q <= code_i;
    end
  end

  assign tone_o = tone_q;

endmodule

// File: rtl/chime_player.sv
module chime_player
  import chime_pkg::*;
#(
  parameter int unsigned CLK_HZ      = 12_000_000,
  parameter int unsigned NOTE_CYCLES = 3_000_000,
  parameter int unsigned CNT_W       = 16,
  parameter int unsigned WINDOW_TENS = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       chime_en,
  input  logic [3:0] min_tens,
  input  logic [3:0] min_ones,
  input  logic [3:0] sec_tens,
  input  logic       rx_valid,
  input  logic [7:0] rx_byte,
  input  logic       tick_1hz,
  output logic       buzzer,
  output logic       hold_display,
  output logic       report_req
);

  logic             rst_q;
  logic             window;
  logic             top_now;
  note_code_t       mel_code, str_code, sel_code;
  logic [CNT_W-1:0] half;
  logic             hold;
  logic             seen_q, seen_d;
  logic             rep_q, rep_d;

  chime_rst_sync u_rst (
    .clk   (clk),
    .rst_n (rst_n),
    .rst_q (rst_q)
  );

  assign top_now = (min_tens == 4'd0) && (min_ones == 4'd0);
  assign window  = chime_en && top_now && (sec_tens < 4'(WINDOW_TENS));

  chime_stream_ctl u_stream (
    .clk      (clk),
    .rst_n    (rst_q),
    .rx_valid (rx_valid),
    .rx_byte  (rx_byte),
    .tick_1hz (tick_1hz),
    .hold_o   (hold),
    .code_o   (str_code)
  );

  chime_melody_seq #(.NOTE_CYCLES(NOTE_CYCLES)) u_melody (
    .clk      (clk),
    .rst_n    (rst_q),
    .window_i (window),
    .code_o   (mel_code)
  );

  always_comb begin
    sel_code = '0;
    if (window) begin
      sel_code = mel_code;
    end else if (hold) begin
      sel_code = str_code;
    end
  end

  chime_pitch_rom #(.CLK_HZ(CLK_HZ), .CNT_W(CNT_W)) u_rom (
    .code_i (sel_code),
    .half_o (half)
  );

  chime_tone_gen #(.CNT_W(CNT_W)) u_tone (
    .clk    (clk),
    .rst_n  (rst_q),
    .code_i (sel_code),
    .half_i (half),
    .tone_o (buzzer)
  );

  // Hour-boundary report: first tick that sees 00 minutes and seconds tens 0.
  always_comb begin
    seen_d = seen_q;
    rep_d  = 1'b0;
    if (tick_1hz) begin
      seen_d = top_now && (sec_tens == 4'd0);
      rep_d  = top_now && (sec_tens == 4'd0) && !seen_q;
    end
  end

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      seen_q <= 1'b0;
      rep_q  <= 1'b0;
    end else begin
      seen_q <= seen_d;
      rep_q  <= rep_d;
    end
  end

  assign hold_display = hold;
  assign report_req   = rep_q;

endmodule

// File: rtl/chime_player_chk.sv
module chime_player_chk #(
  parameter int unsigned WINDOW_TENS = 3
) (
  input logic       clk,
  input logic       rst_q,
  input logic       chime_en,
  input logic [3:0] min_tens,
  input logic [3:0] min_ones,
  input logic [3:0] sec_tens,
  input logic       rx_valid,
  input logic       tick_1hz,
  input logic       buzzer,
  input logic       hold_display,
  input logic       report_req
);

  logic win;
  assign win = chime_en && min_tens == 4'd0 && min_ones == 4'd0 &&
               sec_tens < 4'(WINDOW_TENS);

  p_hold_after_byte_r4: assert property (@(posedge clk) disable iff (!rst_q)
    rx_valid |=> hold_display);

  p_release_on_tick_r5: assert property (@(posedge clk) disable iff (!rst_q)
    $fell(hold_display) |-> $past(tick_1hz) && !$past(rx_valid));

  p_quiet_idle_r7: assert property (@(posedge clk) disable iff (!rst_q)
    (!win && !hold_display) |=> !buzzer);

  p_no_enable_r10: assert property (@(posedge clk) disable iff (!rst_q)
    (!chime_en && !hold_display) |=> !buzzer);

  p_report_single_r9: assert property (@(posedge clk) disable iff (!rst_q)
    report_req |=> !report_req);

  p_report_cause_r9: assert property (@(posedge clk) disable iff (!rst_q)
    report_req |-> $past(tick_1hz) && $past(min_tens == 4'd0) &&
                   $past(min_ones == 4'd0) && $past(sec_tens == 4'd0));

endmodule

bind chime_player chime_player_chk #(.WINDOW_TENS(WINDOW_TENS)) u_chk (
  .clk          (clk),
  .rst_q        (rst_q),
  .chime_en     (chime_en),
  .min_tens     (min_tens),
  .min_ones     (min_ones),
  .sec_tens     (sec_tens),
  .rx_valid     (rx_valid),
  .tick_1hz     (tick_1hz),
  .buzzer       (buzzer),
  .hold_display (hold_display),
  .report_req   (report_req)
);

// File: tb/tb_chime_player.sv
module tb_chime_player;

  localparam int CLK_HZ = 120_000;
  localparam int NOTE   = 1200;

  logic       clk;
  logic       rst_n;
  logic       chime_en;
  logic [3:0] min_tens, min_ones, sec_tens;
  logic       rx_valid;
  logic [7:0] rx_byte;
  logic       tick_1hz;
  logic       buzzer, hold_display, report_req;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  int MEL [64] = '{10,10,11,12,12,11,10,9,8,8,9,10,3,2,2,10,
                   10,11,12,12,11,10,9,8,8,9,10,2,1,1,9,9,
                   10,8,9,10,11,10,8,9,10,11,10,9,8,9,5,10,
                   10,10,11,12,12,11,10,11,9,8,8,9,10,2,8,8};
  longint BASE [7] = '{26163, 29366, 32963, 34923, 39200, 44000, 49388};

  chime_player #(.CLK_HZ(CLK_HZ), .NOTE_CYCLES(NOTE)) dut (
    .clk(clk), .rst_n(rst_n), .chime_en(chime_en),
    .min_tens(min_tens), .min_ones(min_ones), .sec_tens(sec_tens),
    .rx_valid(rx_valid), .rx_byte(rx_byte), .tick_1hz(tick_1hz),
    .buzzer(buzzer), .hold_display(hold_display), .report_req(report_req)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  function automatic int dhalf(int code);
    longint f;
    f = BASE[(code - 1) % 7] << ((code - 1) / 7);
    return int'((64'(CLK_HZ) * 100) / (2 * f));
  endfunction

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  task automatic measure(output int hp, output int used);
    logic prev;
    int n;
    hp = 0; used = 0; n = 0;
    prev = buzzer;
    while (buzzer == prev && n < 2000) begin @(negedge clk); n++; end
    used = n;
    if (n >= 2000) return;
    prev = buzzer; n = 0;
    while (buzzer == prev && n < 2000) begin @(negedge clk); n++; end
    used += n;
    if (n < 2000) hp = n;
  endtask

  task automatic count_high(int n, output int hi);
    hi = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (buzzer) hi++;
    end
  endtask

  task automatic send_byte(int b);
    rx_valid = 1'b1; rx_byte = 8'(b);
    @(negedge clk);
    rx_valid = 1'b0; rx_byte = 8'h00;
  endtask

  task automatic pulse_tick(output logic rep_now, output logic rep_next);
    tick_1hz = 1'b1;
    @(negedge clk);
    tick_1hz = 1'b0;
    rep_now = report_req;
    @(negedge clk);
    rep_next = report_req;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual %0d expected %0d", 1, 0);
    finish_run();
  end

  initial begin
    int hp, used, hi, t;
    logic r1, r2;
    rst_n = 1'b0; chime_en = 1'b0; min_tens = 4'd5; min_ones = 4'd0;
    sec_tens = 4'd0; rx_valid = 1'b0; rx_byte = 8'h00; tick_1hz = 1'b0;
    repeat (5) @(negedge clk);
    chk("R1 buzzer in reset", int'(buzzer), 0);
    chk("R1 hold in reset", int'(hold_display), 0);
    chk("R1 report in reset", int'(report_req), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 buzzer after reset", int'(buzzer), 0);
    chk("R1 hold after reset", int'(hold_display), 0);

    // R2, R4: every note code streamed in turn
    for (int c = 1; c <= 21; c++) begin
      send_byte(c);
      chk("R4 hold after byte", int'(hold_display), 1);
      measure(hp, used);
      chk($sformatf("R2 half period code %0d", c), hp, dhalf(c));
    end

    // R3: codes outside the note range are silent but still hold
    foreach (MEL[i]) if (i < 4) begin
      int bad;
      bad = (i == 0) ? 0 : (i == 1) ? 8'h16 : (i == 2) ? 8'h80 : 8'hFF;
      send_byte(bad);
      chk("R3 hold on silent code", int'(hold_display), 1);
      count_high(600, hi);
      chk($sformatf("R3 silent code %0d", bad), hi, 0);
    end

    // R5: release timing of the hold
    pulse_tick(r1, r2);
    chk("R5 first tick keeps hold", int'(hold_display), 1);
    pulse_tick(r1, r2);
    chk("R5 second tick releases", int'(hold_display), 0);
    send_byte(3);
    pulse_tick(r1, r2);
    send_byte(4);
    pulse_tick(r1, r2);
    chk("R5 byte between ticks keeps hold", int'(hold_display), 1);
    pulse_tick(r1, r2);
    chk("R5 quiet interval releases", int'(hold_display), 0);
    rx_valid = 1'b1; rx_byte = 8'd5; tick_1hz = 1'b1;
    @(negedge clk);
    rx_valid = 1'b0; tick_1hz = 1'b0;
    chk("R5 byte with tick holds", int'(hold_display), 1);
    pulse_tick(r1, r2);
    chk("R5 tick after coincident byte keeps", int'(hold_display), 1);
    pulse_tick(r1, r2);
    chk("R5 release after coincident byte", int'(hold_display), 0);

    // R7: idle is silent
    count_high(500, hi);
    chk("R7 idle buzzer low", hi, 0);

    // R6: full melody including wrap 63 -> 0
    chime_en = 1'b1; min_tens = 4'd0; min_ones = 4'd0; sec_tens = 4'd0;
    t = 0;
    for (int s = 0; s <= 64; s++) begin
      repeat (s * NOTE + 100 - t) @(negedge clk);
      t = s * NOTE + 100;
      measure(hp, used);
      t += used;
      chk($sformatf("R6 melody step %0d", s), hp, dhalf(MEL[s % 64]));
    end

    // R7: window end silences, reopening restarts at step 0
    sec_tens = 4'd3;
    count_high(300, hi);
    chk("R7 window closed low", hi, 0);
    sec_tens = 4'd0;
    repeat (100) @(negedge clk);
    measure(hp, used);
    chk("R7 restart step 0", hp, dhalf(MEL[0]));
    repeat (2 * NOTE - 100 - used) @(negedge clk);
    measure(hp, used);
    chk("R7 restart step 2", hp, dhalf(MEL[2]));

    // R10: enable low suppresses melody; R6: nonzero minute closes window
    chime_en = 1'b0;
    count_high(400, hi);
    chk("R10 disabled chime low", hi, 0);
    chime_en = 1'b1; min_ones = 4'd1;
    count_high(400, hi);
    chk("R6 minute 01 closed", hi, 0);

    // R8: melody overrides a streamed note
    min_ones = 4'd0; sec_tens = 4'd3;
    send_byte(1);
    measure(hp, used);
    chk("R8 stream plays outside window", hp, dhalf(1));
    sec_tens = 4'd0;
    repeat (100) @(negedge clk);
    measure(hp, used);
    chk("R8 melody wins", hp, dhalf(MEL[0]));
    chk("R8 hold kept", int'(hold_display), 1);

    // R9: report pulse
    pulse_tick(r1, r2);
    chk("R9 report at hour", int'(r1), 1);
    chk("R9 report one cycle", int'(r2), 0);
    pulse_tick(r1, r2);
    chk("R9 no repeat same hour", int'(r1), 0);
    sec_tens = 4'd1;
    pulse_tick(r1, r2);
    chk("R9 none at 00:1x", int'(r1), 0);
    chime_en = 1'b0; sec_tens = 4'd0;
    pulse_tick(r1, r2);
    chk("R9 report with chime off", int'(r1), 1);
    chk("R9 width with chime off", int'(r2), 0);

    finish_run();
  end

endmodule